// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog that has to be serviced periodically by software through a small memory-mapped register interface. A prescaler turns the core clock into a slow tick. Two countdown stages share that tick. The first stage runs from its own preload. When it runs out, it sets an interrupt status bit and hands over to the second stage. When the second stage runs out, the block sets a sticky timeout flag and drives a reset request pulse of fixed length. The counters then start again from the first stage.

The reload/control register and both preload registers are guarded. A write to any of them takes effect only if it directly follows a two-value key sequence written to the reload register. A key sequence opens exactly one write, and that write may go to any address. A separate lock register starts and stops the watchdog. Once its lock bit is set, the watchdog cannot be disabled again until the block's own reset. A configuration register selects the prescale ratio, the interrupt type and whether the reset output is driven.

The reset request only asks for a system reset. It does not reset this block, so the timeout flag can still be read after the pulse. Only `rst_ni` returns the block to its reset state.

Top module: `twostage_wdt`

## Requirements
- R1: The preload registers (0x00 stage 1, 0x04 stage 2) and the reload register (0x0C) change only when the write directly follows the key sequence. The key sequence is a write of 0x0080 and then a write of 0x0086 to 0x0C, compared on wdata bits 15:0. Any other write in between breaks the sequence.
- R2: An open key sequence is used up by the very next write to any address. A second protected write after one key sequence is ignored.
- R3: A protected write to 0x0C with bit 8 set is a keepalive. It reloads stage 1, selects stage 1 and restarts the prescaler from zero.
- R4: While the watchdog runs, stage 1 expires on the (P1+1)-th tick after a start or keepalive, where P1 is the value in 0x00. The expiry sets bit 0 of 0x08. Writing 1 to bit 0 of 0x08 clears it, and writing 0 leaves it set.
- R5: irq_o equals bit 0 of 0x08 unless configuration bits 1:0 of 0x10 are 11, in which case irq_o stays low.
- R6: Stage 2 starts from P2 (the value in 0x04) and expires on its (P2+1)-th tick. The expiry starts a reset request lasting RST_PULSE clock cycles. rst_req_o shows that request only while configuration bit 5 is 0.
- R7: Bit 9 of 0x0C is a sticky flag set by a stage-2 expiry. It stays readable after the reset request ends. Only a protected write of 1 to bit 9 clears it.
- R8: In the lock register 0x14, bit 1 is enable, bit 0 is lock and bit 2 is function select. While lock is 1, enable and lock cannot be cleared and function select is frozen.
- R9: The watchdog runs only while enable is 1 and function select is 0. Otherwise no tick is produced, the stages hold at their preloads, and no interrupt or reset request appears.
- R10: Configuration bit 2 of 0x10 selects the tick period. A 1 gives 2^DIV_FAST_LOG clock cycles and a 0 gives 2^DIV_SLOW_LOG clock cycles, counted from a start or a keepalive.
- R11: After reset both preloads read PRE_RESET, and all other registers, irq_o and rst_req_o read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| addr_i | input | 5 | Byte offset of the register access |
| wr_i | input | 1 | Write strobe, one write per cycle in which it is high |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| irq_o | output | 1 | Stage-1 interrupt level |
| rst_req_o | output | 1 | Reset request pulse on stage-2 expiry |

## Verification
The bench builds the block with DIV_SLOW_LOG = 4, DIV_FAST_LOG = 2 and RST_PULSE = 4, and keeps the 20-bit preloads. With these values a full two-stage expiry takes a few hundred cycles at most. Random cases can therefore measure the exact cycle of the interrupt, the exact cycle and width of the reset request, and both prescale settings against the (P+1)-tick rule. Directed cases cover broken and repeated key sequences, a keepalive loop that must keep the interrupt away, and the function-select hold. The sticky lock case runs last and is followed by a block reset.

// File: rtl/twostage_wdt_pkg.sv
package twostage_wdt_pkg;
   localparam int OFS_W = 5;
   localparam logic [OFS_W-1:0] OFS_PRE1   = 5'h00;
   localparam logic [OFS_W-1:0] OFS_PRE2   = 5'h04;
   localparam logic [OFS_W-1:0] OFS_ISTS   = 5'h08;
   localparam logic [OFS_W-1:0] OFS_RELOAD = 5'h0C;
   localparam logic [OFS_W-1:0] OFS_CFG    = 5'h10;
   localparam logic [OFS_W-1:0] OFS_LOCK   = 5'h14;

   localparam logic [15:0] KEY_FIRST  = 16'h0080;
   localparam logic [15:0] KEY_SECOND = 16'h0086;

   localparam int RLD_KICK_BIT   = 8;
   localparam int RLD_FLAG_BIT   = 9;
   localparam int CFG_OUTDIS_BIT = 5;
   localparam int CFG_FAST_BIT   = 2;
   localparam int LK_LOCK_BIT    = 0;
   localparam int LK_EN_BIT      = 1;
   localparam int LK_FUNC_BIT    = 2;

   typedef enum logic [1:0] {
      UL_SHUT = 2'd0,
      UL_HALF = 2'd1,
      UL_OPEN = 2'd2
   } ul_state_e;
endpackage

// File: rtl/twostage_wdt_unlock.sv
module twostage_wdt_unlock
   import twostage_wdt_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        wr_i,
   input  logic        hit_reload_i,
   input  logic [15:0] key_i,
   output logic        open_o
);
   ul_state_e state_q;
   logic      is_first, is_second;

   assign is_first  = hit_reload_i && (key_i == KEY_FIRST);
   assign is_second = hit_reload_i && (key_i == KEY_SECOND);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= UL_SHUT;
      end else if (wr_i) begin
         unique case (state_q)
            UL_SHUT: state_q <= is_first ? UL_HALF : UL_SHUT;
            UL_HALF: state_q <= is_second ? UL_OPEN : (is_first ? UL_HALF : UL_SHUT);
            default: state_q <= UL_SHUT;
         endcase
      end
   end

   assign open_o = (state_q == UL_OPEN);
endmodule

// File: rtl/twostage_wdt_prescale.sv
module twostage_wdt_prescale #(
   parameter int SLOW_LOG = 15,
   parameter int FAST_LOG = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic restart_i,
   input  logic fast_i,
   output logic tick_o
);
   logic [SLOW_LOG-1:0] cnt_q;
   logic                wrap;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (!run_i || restart_i) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
   end

   assign wrap   = fast_i ? (&cnt_q[FAST_LOG-1:0]) : (&cnt_q);
   assign tick_o = run_i && !restart_i && wrap;
endmodule

// File: rtl/twostage_wdt_stages.sv
module twostage_wdt_stages #(
   parameter int CNT_W = 20
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             tick_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] pre1_i,
   input  logic [CNT_W-1:0] pre2_i,
   output logic             s1_exp_o,
   output logic             s2_exp_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             second_q;
   logic             at_zero;

   assign at_zero  = (cnt_q == '0);
   assign s1_exp_o = tick_i && at_zero && !second_q;
   assign s2_exp_o = tick_i && at_zero && second_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         second_q <= 1'b0;
      end else if (!run_i || reload_i) begin
         cnt_q    <= pre1_i;
         second_q <= 1'b0;
      end else if (tick_i) begin
         if (!at_zero) begin
            cnt_q <= cnt_q - 1'b1;
         end else if (second_q) begin
            cnt_q    <= pre1_i;
            second_q <= 1'b0;
         end else begin
            cnt_q    <= pre2_i;
            second_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/twostage_wdt_pulse.sv
module twostage_wdt_pulse #(
   parameter int LEN = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fire_i,
   output logic pulse_o
);
   generate
      if (LEN == 1) begin : g_single
         logic q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q <= 1'b0;
            else         q <= fire_i;
         end
         assign pulse_o = q;
      end else begin : g_count
         localparam int PW = $clog2(LEN + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)              left_q <= '0;
            else if (fire_i)          left_q <= PW'(LEN);
            else if (left_q != '0)    left_q <= left_q - 1'b1;
         end
         assign pulse_o = (left_q != '0);
      end
   endgenerate
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
   import twostage_wdt_pkg::*;
#(
   parameter int              PRE_W        = 20,
   parameter int              DATA_W       = 32,
   parameter int              DIV_SLOW_LOG = 15,
   parameter int              DIV_FAST_LOG = 5,
   parameter int              RST_PULSE    = 16,
   parameter logic [PRE_W-1:0] PRE_RESET   = 20'h03C00
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [OFS_W-1:0]  addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o,
   output logic              rst_req_o
);
   generate
      if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre
         $error("PRE_W must lie between 1 and DATA_W");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold at least the 16-bit key");
      end
      if (DIV_FAST_LOG < 1 || DIV_FAST_LOG >= DIV_SLOW_LOG) begin : g_bad_div
         $error("DIV_FAST_LOG must be at least 1 and below DIV_SLOW_LOG");
      end
      if (RST_PULSE < 1) begin : g_bad_pulse
         $error("RST_PULSE must be at least 1");
      end
   endgenerate

   logic [PRE_W-1:0] pre1_q, pre2_q;
   logic             ists_q, flag_q;
   logic             outdis_q, fast_q;
   logic [1:0]       itype_q;
   logic             lock_q, en_q, func_q;
   logic             ul_open, prot_ok, run, tick, kick, flag_clr;
   logic             s1_exp, s2_exp, pulse;
   logic             hit_pre1, hit_pre2, hit_ists, hit_rld, hit_cfg, hit_lock;

   assign hit_pre1 = (addr_i == OFS_PRE1);
   assign hit_pre2 = (addr_i == OFS_PRE2);
   assign hit_ists = (addr_i == OFS_ISTS);
   assign hit_rld  = (addr_i == OFS_RELOAD);
   assign hit_cfg  = (addr_i == OFS_CFG);
   assign hit_lock = (addr_i == OFS_LOCK);

   twostage_wdt_unlock u_unlock (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (wr_i),
      .hit_reload_i (hit_rld),
      .key_i        (wdata_i[15:0]),
      .open_o       (ul_open)
   );

   assign prot_ok  = wr_i && ul_open;
   assign kick     = prot_ok && hit_rld && wdata_i[RLD_KICK_BIT];
   assign flag_clr = prot_ok && hit_rld && wdata_i[RLD_FLAG_BIT];
   assign run      = en_q && !func_q;

   twostage_wdt_prescale #(
      .SLOW_LOG (DIV_SLOW_LOG),
      .FAST_LOG (DIV_FAST_LOG)
   ) u_presc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .restart_i (kick),
      .fast_i    (fast_q),
      .tick_o    (tick)
   );

   twostage_wdt_stages #(.CNT_W(PRE_W)) u_stages (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .tick_i   (tick),
      .reload_i (kick),
      .pre1_i   (pre1_q),
      .pre2_i   (pre2_q),
      .s1_exp_o (s1_exp),
      .s2_exp_o (s2_exp)
   );

   twostage_wdt_pulse #(.LEN(RST_PULSE)) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (s2_exp),
      .pulse_o (pulse)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre1_q <= PRE_RESET;
         pre2_q <= PRE_RESET;
      end else begin
         if (prot_ok && hit_pre1) pre1_q <= wdata_i[PRE_W-1:0];
         if (prot_ok && hit_pre2) pre2_q <= wdata_i[PRE_W-1:0];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ists_q <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (s1_exp)                              ists_q <= 1'b1;
         else if (wr_i && hit_ists && wdata_i[0]) ists_q <= 1'b0;
         if (s2_exp)        flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         outdis_q <= 1'b0;
         fast_q   <= 1'b0;
         itype_q  <= 2'b00;
         lock_q   <= 1'b0;
         en_q     <= 1'b0;
         func_q   <= 1'b0;
      end else begin
         if (wr_i && hit_cfg) begin
            outdis_q <= wdata_i[CFG_OUTDIS_BIT];
            fast_q   <= wdata_i[CFG_FAST_BIT];
            itype_q  <= wdata_i[1:0];
         end
         if (wr_i && hit_lock) begin
            lock_q <= lock_q || wdata_i[LK_LOCK_BIT];
            en_q   <= wdata_i[LK_EN_BIT] || (lock_q && en_q);
            func_q <= lock_q ? func_q : wdata_i[LK_FUNC_BIT];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_pre1) rdata_o[PRE_W-1:0] = pre1_q;
      if (hit_pre2) rdata_o[PRE_W-1:0] = pre2_q;
      if (hit_ists) rdata_o[0] = ists_q;
      if (hit_rld)  rdata_o[RLD_FLAG_BIT] = flag_q;
      if (hit_cfg) begin
         rdata_o[CFG_OUTDIS_BIT] = outdis_q;
         rdata_o[CFG_FAST_BIT]   = fast_q;
         rdata_o[1:0]            = itype_q;
      end
      if (hit_lock) begin
         rdata_o[LK_LOCK_BIT] = lock_q;
         rdata_o[LK_EN_BIT]   = en_q;
         rdata_o[LK_FUNC_BIT] = func_q;
      end
   end

   assign irq_o     = ists_q && (itype_q != 2'b11);
   assign rst_req_o = pulse && !outdis_q;

   logic unused_wdata;
   assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       irq_o,
   input logic       ists_q,
   input logic       flag_q,
   input logic       pulse,
   input logic       run,
   input logic       lock_q,
   input logic       en_q,
   input logic       prot_ok,
   input logic       ul_open,
   input logic [1:0] itype_q
);
   AST_IRQ_TYPE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (ists_q && itype_q != 2'b11));                         // R5
   AST_PULSE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pulse) |-> flag_q);                                         // R6
   AST_LOCK_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |=> lock_q);                                               // R8
   AST_LOCKED_EN_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_q && en_q) |=> en_q);                                       // R8
   AST_ONE_WRITE_PER_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prot_ok |=> !ul_open);                                            // R2
   AST_IDLE_NO_EXPIRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> !$rose(ists_q));                                         // R9
   AST_IDLE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run |=> !$rose(flag_q));                                         // R9
endmodule

bind twostage_wdt twostage_wdt_chk chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .irq_o   (irq_o),
   .ists_q  (ists_q),
   .flag_q  (flag_q),
   .pulse   (pulse),
   .run     (run),
   .lock_q  (lock_q),
   .en_q    (en_q),
   .prot_ok (prot_ok),
   .ul_open (ul_open),
   .itype_q (itype_q)
);

// File: tb/twostage_wdt_tb_top.sv
`timescale 1ns/1ps
module twostage_wdt_tb_top;
   localparam int SLOW = 4;
   localparam int FAST = 2;
   localparam int PLS  = 4;
   localparam logic [19:0] PRST = 20'h03C00;
   localparam logic [4:0] A_P1 = 5'h00, A_P2 = 5'h04, A_IS = 5'h08,
                          A_RL = 5'h0C, A_CF = 5'h10, A_LK = 5'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, rstq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   twostage_wdt #(
      .DIV_SLOW_LOG (SLOW),
      .DIV_FAST_LOG (FAST),
      .RST_PULSE    (PLS)
   ) dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .addr_i    (addr),
      .wr_i      (wr),
      .wdata_i   (wdata),
      .rdata_o   (rdata),
      .irq_o     (irq),
      .rst_req_o (rstq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
      addr = a;
      #0.1;
      d = rdata;
   endtask

   task automatic prot_wr(input logic [4:0] a, input logic [31:0] d);
      wr_reg(A_RL, 32'h80);
      wr_reg(A_RL, 32'h86);
      wr_reg(a, d);
   endtask

   function automatic int tick_len(input bit fast);
      return fast ? (1 << FAST) : (1 << SLOW);
   endfunction

   task automatic setup(input int p1, input int p2, input bit fast,
                        input logic [1:0] it, input bit odis);
      wr_reg(A_LK, 32'h0);
      wr_reg(A_IS, 32'h1);
      prot_wr(A_RL, 32'h200);
      prot_wr(A_P1, p1);
      prot_wr(A_P2, p2);
      wr_reg(A_CF, (32'(odis) << 5) | (32'(fast) << 2) | 32'(it));
   endtask

   task automatic run_case(input int p1, input int p2, input bit fast,
                           input logic [1:0] it, input bit odis);
      int e1, e2, f_sts, f_irq, f_rst, n_rst;
      logic [31:0] v;
      setup(p1, p2, fast, it, odis);
      wr_reg(A_LK, 32'h2);
      e1 = (p1 + 1) * tick_len(fast);
      e2 = (p1 + p2 + 2) * tick_len(fast);
      f_sts = 0; f_irq = 0; f_rst = 0; n_rst = 0;
      addr = A_IS;
      for (int n = 1; n <= e2 + PLS + 3; n++) begin
         @(negedge clk);
         if (rdata[0] && f_sts == 0) f_sts = n;
         if (irq && f_irq == 0) f_irq = n;
         if (rstq) begin
            n_rst++;
            if (f_rst == 0) f_rst = n;
         end
      end
      chk("R4/R10 stage-1 expiry cycle", f_sts, e1);
      chk("R5 irq first cycle", f_irq, (it == 2'b11) ? 0 : e1);
      chk("R6 reset request start", f_rst, odis ? 0 : e2);
      chk("R6 reset request width", n_rst, odis ? 0 : PLS);
      rd_reg(A_RL, v);
      chk("R7 sticky flag after pulse", v[9], 1'b1);
      rd_reg(A_P1, v);
      chk("R1 preload accepted", v, p1);
   endtask

   initial begin
      logic [31:0] v;
      int seed;
      int n, f;
      seed = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      rd_reg(A_P1, v); chk("R11 preload1 reset", v, PRST);
      rd_reg(A_P2, v); chk("R11 preload2 reset", v, PRST);
      rd_reg(A_IS, v); chk("R11 status reset", v, 0);
      rd_reg(A_RL, v); chk("R11 reload reset", v, 0);
      rd_reg(A_CF, v); chk("R11 config reset", v, 0);
      rd_reg(A_LK, v); chk("R11 lock reset", v, 0);
      chk("R11 irq reset", irq, 0);
      chk("R11 rst_req reset", rstq, 0);

      // R1 no key, broken key
      wr_reg(A_P1, 32'd5);
      rd_reg(A_P1, v); chk("R1 write without key ignored", v, PRST);
      wr_reg(A_RL, 32'h80); wr_reg(A_RL, 32'h99); wr_reg(A_RL, 32'h86);
      wr_reg(A_P1, 32'd7);
      rd_reg(A_P1, v); chk("R1 broken key ignored", v, PRST);
      prot_wr(A_P1, 32'd9);
      rd_reg(A_P1, v); chk("R1 keyed write accepted", v, 9);
      // R2 one write per key
      wr_reg(A_P1, 32'd11);
      rd_reg(A_P1, v); chk("R2 second write ignored", v, 9);
      prot_wr(A_CF, 32'h0);
      wr_reg(A_P1, 32'd12);
      rd_reg(A_P1, v); chk("R2 key used by other address", v, 9);

      // random cases (R4 R5 R6 R7 R10)
      for (int i = 0; i < 16; i++) begin
         run_case($urandom_range(0, 9), $urandom_range(0, 9), 1'($urandom_range(0, 1)),
                  2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      end
      run_case(0, 0, 1'b1, 2'b00, 1'b0);

      // R7 flag clear needs key
      wr_reg(A_LK, 32'h0);
      wr_reg(A_RL, 32'h200);
      rd_reg(A_RL, v); chk("R7 flag clear without key ignored", v[9], 1'b1);
      prot_wr(A_RL, 32'h200);
      rd_reg(A_RL, v); chk("R7 flag cleared by keyed write", v[9], 1'b0);
      // R4 W1C
      wr_reg(A_IS, 32'h0);
      rd_reg(A_IS, v); chk("R4 write 0 keeps status", v[0], 1'b1);
      wr_reg(A_IS, 32'h1);
      rd_reg(A_IS, v); chk("R4 write 1 clears status", v[0], 1'b0);

      // R3 keepalive keeps stage 1 from expiring, then restarts timing
      setup(2, 2, 1'b1, 2'b00, 1'b0);
      wr_reg(A_LK, 32'h2);
      for (int k = 0; k < 12; k++) begin
         prot_wr(A_RL, 32'h100);
         @(negedge clk); @(negedge clk);
      end
      rd_reg(A_IS, v); chk("R3 keepalive prevents expiry", v[0], 1'b0);
      prot_wr(A_RL, 32'h100);
      addr = A_IS; f = 0; n = 0;
      for (int m = 1; m <= 20; m++) begin
         @(negedge clk);
         if (rdata[0] && f == 0) f = m;
      end
      chk("R3 restart from keepalive", f, 3 * tick_len(1'b1));

      // R9 function select and disable hold the watchdog
      setup(0, 0, 1'b1, 2'b00, 1'b0);
      wr_reg(A_LK, 32'h6);
      n = 0;
      for (int m = 0; m < 200; m++) begin
         @(negedge clk);
         if (irq || rstq) n++;
      end
      chk("R9 function select holds", n, 0);
      rd_reg(A_RL, v); chk("R9 no flag when held", v[9], 1'b0);
      wr_reg(A_LK, 32'h0);
      repeat (100) @(negedge clk);
      rd_reg(A_IS, v); chk("R9 disabled holds", v[0], 1'b0);

      // R8 sticky lock
      wr_reg(A_LK, 32'h3);
      wr_reg(A_LK, 32'h0);
      rd_reg(A_LK, v); chk("R8 lock keeps enable", v, 32'h3);
      wr_reg(A_LK, 32'h4);
      rd_reg(A_LK, v); chk("R8 function frozen", v, 32'h3);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_reg(A_LK, v); chk("R11 lock cleared by reset", v, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule